// File: doc/BRIEF.md
# Masked CRC-16 Wake-Frame Filter

This block watches the byte stream of a received Ethernet frame and decides whether the frame matches one programmed wake-up pattern. A byte window begins at a programmable offset, counted from the first destination address byte. A 32-bit byte mask picks bytes out of that window, and only the picked bytes are folded into a CRC-16. When the frame ends, the block compares the accumulated CRC with a programmed 16-bit value. If they are equal, the frame reported good by the MAC, the filter enabled, and every masked byte actually received, the block raises a single-cycle wake pulse.

The receive path presents one byte per cycle when `rx_valid` is high. `rx_sof` marks the first destination address byte and `rx_eof` marks the last byte. `rx_good` is qualified by `rx_eof`. The configuration inputs must stay stable for the whole of a frame.

Top module: `wake_crc_filter`

## Requirements
- R1: Byte positions count from 0, where 0 is the byte accepted with `rx_sof`. The window begins at the position given by `cfg_offset`.
- R2: An offset below 12 acts as 12. Positions 0 to 11 never contribute to the CRC.
- R3: Mask bit n selects the byte at position offset+n. Unselected bytes and bytes at or beyond offset+32 leave the CRC unchanged.
- R4: The CRC is preset to 0xFFFF at each frame start. Each selected byte is processed least significant bit first. For each bit, feedback = crc[15] xor bit, the register shifts left by one, and 0x8005 is XORed in when feedback is 1. There is no final inversion. A match requires the result to equal `cfg_crc`.
- R5: `wake_pulse` is high for exactly one cycle, in the cycle after the clock edge that accepts the `rx_eof` byte. It rises only if `rx_good` and `cfg_enable` are both high with that byte.
- R6: If the frame ends before the byte at offset+(highest set mask bit) arrives, no pulse is raised. With an all-zero mask, no byte is required and the CRC stays 0xFFFF.
- R7: Cycles with `rx_valid` low are ignored whatever the other inputs carry. Valid bytes that arrive outside a frame (after `rx_eof`, before `rx_sof`) are ignored. An `rx_sof` inside a frame restarts the frame.
- R8: Reset drives `wake_pulse` low and abandons any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Filter enable |
| cfg_offset | input | 8 | Window start position |
| cfg_mask | input | 32 | Byte select mask for the window |
| cfg_crc | input | 16 | Expected CRC-16 |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_good | input | 1 | Frame received without error (with rx_eof) |
| rx_data | input | 8 | Frame byte |
| wake_pulse | output | 1 | One-cycle wake-up frame indication |

## Verification
The bench targets four kinds of corner case.

Frames that stop exactly one byte short of the highest masked byte, and frames that just reach it, separate a design that ignores coverage from one that is off by one. Either fault shows up as a wrong pulse on the shorter frame or a missing pulse on the longer one.

Offsets below 12, an offset of 255, and a mask with bit 31 set expose a missing clamp or a mis-indexed mask. Such a design folds the wrong bytes into the CRC and misses the expected match.

Idle cycles carrying stray start and end flags, bytes outside any frame, a restart in mid-frame and a reset in mid-frame catch designs that track frame state loosely. Those designs pulse spuriously or miss a match.

Bad-frame, disabled and wrong-CRC frames catch a design that fires without all of its qualifiers.

// File: rtl/wf_pkg.sv
package wf_pkg;

    localparam int          MIN_OFFSET = 12;
    localparam logic [15:0] CRC_POLY   = 16'h8005;
    localparam logic [15:0] CRC_INIT   = 16'hFFFF;

    typedef struct packed {
        logic       valid;
        logic       sof;
        logic       eof;
        logic       good;
        logic [7:0] data;
    } rx_beat_t;

    // Fold one byte into the CRC, least significant bit first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                               input logic [7:0]  data);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            fb = c[15] ^ data[b];
            c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return c;
    endfunction

endpackage

// File: rtl/wf_byte_tracker.sv
module wf_byte_tracker
    import wf_pkg::*;
#(
    parameter int POS_W = 12,
    parameter int OFF_W = 8,
    parameter int WIN   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_act,
    input  logic             byte_sof,
    input  logic [OFF_W-1:0] cfg_offset,
    input  logic [WIN-1:0]   cfg_mask,
    output logic             byte_sel,
    output logic             covered
);
    localparam int IDX_W = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic [POS_W-1:0] pos_q;
    logic             reach_q;
    logic [POS_W-1:0] cur_pos;
    logic [POS_W-1:0] eff_off;
    logic [POS_W-1:0] rel;
    logic [POS_W-1:0] target;
    logic [IDX_W-1:0] hi_idx;
    logic             any_set;
    logic             in_win;
    logic             reach_prev;
    logic             hit_now;

    // Clamp the window start so the address fields stay excluded.
    assign eff_off = (cfg_offset < OFF_W'(MIN_OFFSET)) ? POS_W'(MIN_OFFSET)
                                                       : POS_W'(cfg_offset);

    always_comb begin
        hi_idx  = '0;
        any_set = 1'b0;
        for (int i = 0; i < WIN; i++) begin
            if (cfg_mask[i]) begin
                hi_idx  = IDX_W'(i);
                any_set = 1'b1;
            end
        end
    end

    assign cur_pos    = byte_sof ? '0 : pos_q;
    assign rel        = cur_pos - eff_off;
    assign target     = eff_off + POS_W'(hi_idx);
    assign in_win     = (cur_pos >= eff_off) && (rel < POS_W'(WIN));
    assign byte_sel   = byte_act && in_win && cfg_mask[rel[IDX_W-1:0]];
    assign reach_prev = byte_sof ? 1'b0 : reach_q;
    assign hit_now    = byte_act && (cur_pos == target);
    assign covered    = !any_set || reach_prev || hit_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            reach_q <= 1'b0;
        end else if (byte_act) begin
            pos_q   <= (cur_pos == POS_MAX) ? POS_MAX : cur_pos + 1'b1;
            reach_q <= reach_prev || hit_now;
        end
    end

    assert_sel_after_header_R2: assert property (@(posedge clk) disable iff (rst)
        byte_sel |-> (cur_pos >= POS_W'(MIN_OFFSET)));

    assert_pos_restart_R1: assert property (@(posedge clk) disable iff (rst)
        (byte_act && byte_sof) |=> (pos_q == POS_W'(1)));

endmodule

// File: rtl/wf_crc_unit.sv
module wf_crc_unit
    import wf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_act,
    input  logic        byte_sof,
    input  logic        byte_sel,
    input  logic [7:0]  byte_data,
    output logic [15:0] crc_next
);
    logic [15:0] crc_q;
    logic [15:0] crc_base;

    assign crc_base = byte_sof ? CRC_INIT : crc_q;
    assign crc_next = byte_sel ? crc16_byte(crc_base, byte_data) : crc_base;

    always_ff @(posedge clk) begin
        if (rst)           crc_q <= CRC_INIT;
        else if (byte_act) crc_q <= crc_next;
    end

    assert_idle_holds_crc_R7: assert property (@(posedge clk) disable iff (rst)
        !byte_act |=> $stable(crc_q));

    assert_unselected_keeps_crc_R3: assert property (@(posedge clk) disable iff (rst)
        (byte_act && !byte_sof && !byte_sel) |=> $stable(crc_q));

endmodule

// File: rtl/wake_crc_filter.sv
module wake_crc_filter
    import wf_pkg::*;
#(
    parameter int OFF_W = 8,
    parameter int WIN   = 32,
    parameter int CRC_W = 16,
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic [OFF_W-1:0] cfg_offset,
    input  logic [WIN-1:0]   cfg_mask,
    input  logic [CRC_W-1:0] cfg_crc,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             rx_good,
    input  logic [7:0]       rx_data,
    output logic             wake_pulse
);
    rx_beat_t    beat;
    logic        in_frame_q;
    logic        act;
    logic        sel;
    logic        covered;
    logic [15:0] crc_next;
    logic        fire;
    logic        wake_q;

    assign beat = '{valid: rx_valid, sof: rx_sof, eof: rx_eof,
                    good: rx_good, data: rx_data};
    assign act  = beat.valid && (beat.sof || in_frame_q);

    always_ff @(posedge clk) begin
        if (rst)      in_frame_q <= 1'b0;
        else if (act) in_frame_q <= !beat.eof;
    end

    wf_byte_tracker #(.POS_W(POS_W), .OFF_W(OFF_W), .WIN(WIN)) u_track (
        .clk        (clk),
        .rst        (rst),
        .byte_act   (act),
        .byte_sof   (beat.sof),
        .cfg_offset (cfg_offset),
        .cfg_mask   (cfg_mask),
        .byte_sel   (sel),
        .covered    (covered)
    );

    wf_crc_unit u_crc (
        .clk       (clk),
        .rst       (rst),
        .byte_act  (act),
        .byte_sof  (beat.sof),
        .byte_sel  (sel),
        .byte_data (beat.data),
        .crc_next  (crc_next)
    );

    assign fire = act && beat.eof && beat.good && cfg_enable && covered
                  && (CRC_W'(crc_next) == cfg_crc);

    always_ff @(posedge clk) begin
        if (rst) wake_q <= 1'b0;
        else     wake_q <= fire;
    end

    assign wake_pulse = wake_q;

    assert_pulse_qualified_R5: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> $past(rx_valid && rx_eof && rx_good && cfg_enable));

    assert_pulse_needs_cover_R6: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> $past(covered));

    assert_pulse_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> $past(rx_sof || in_frame_q));

endmodule

// File: tb/tb_wake_crc_filter.sv
module tb_wake_crc_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0;
    logic [7:0]  cfg_offset = 8'd12;
    logic [31:0] cfg_mask = '0;
    logic [15:0] cfg_crc = '0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic        rx_good = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        wake_pulse;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wake_crc_filter dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_offset(cfg_offset),
        .cfg_mask(cfg_mask), .cfg_crc(cfg_crc), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_good(rx_good),
        .rx_data(rx_data), .wake_pulse(wake_pulse)
    );

    always @(negedge clk) if (!rst && wake_pulse) pulses++;

    typedef struct packed {
        logic [7:0]  off;
        logic [31:0] mask;
        logic [15:0] len;
        logic [7:0]  seed;
        logic        gaps;
        logic        good;
        logic        en;
        logic        ok;
        logic        exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'd12,  32'h0000000F, 16'd64,  8'd1,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R1 R4
        '{8'd20,  32'h80000001, 16'd60,  8'd2,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R3 R7
        '{8'd20,  32'h80000001, 16'd51,  8'd3,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 short
        '{8'd20,  32'h80000001, 16'd52,  8'd3,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R6 just enough
        '{8'd5,   32'h000000FF, 16'd40,  8'd4,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R2
        '{8'd0,   32'h00000003, 16'd20,  8'd5,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R2
        '{8'd14,  32'h00F0F00F, 16'd80,  8'd6,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R4 wrong crc
        '{8'd14,  32'h00F0F00F, 16'd80,  8'd6,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 bad frame
        '{8'd14,  32'h00F0F00F, 16'd80,  8'd6,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 disabled
        '{8'd40,  32'h00000000, 16'd20,  8'd7,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R6 empty mask
        '{8'd255, 32'h00000001, 16'd300, 8'd9,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R1 top offset
        '{8'd12,  32'hFFFFFFFF, 16'd44,  8'd10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R3 R6 at eof
        '{8'd12,  32'hFFFFFFFF, 16'd43,  8'd10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}  // R6 one short
    };

    function automatic logic [7:0] fbyte(input logic [7:0] seed, input int i);
        return 8'((int'(seed) * 7 + i * 29) ^ (i >> 2));
    endfunction

    function automatic logic [15:0] ref_crc(input logic [7:0] off, input logic [31:0] mask,
                                            input int len, input logic [7:0] seed);
        logic [15:0] c = 16'hFFFF;
        int          start = (off < 8'd12) ? 12 : int'(off);
        logic [7:0]  d;
        logic        f;
        for (int i = 0; i < len; i++) begin
            if (i >= start && i - start < 32 && mask[i - start]) begin
                d = fbyte(seed, i);
                for (int k = 0; k < 8; k++) begin
                    f = c[15] ^ d[k];
                    c = {c[14:0], 1'b0};
                    if (f) c = c ^ 16'h8005;
                end
            end
        end
        return c;
    endfunction

    task automatic check(input bit cond, input string what, input int act, input int expv);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    task automatic drive(input bit v, input bit s, input bit e, input bit g, input logic [7:0] d);
        @(negedge clk);
        rx_valid = v; rx_sof = s; rx_eof = e; rx_good = g; rx_data = d;
    endtask

    // Sends a frame; the last byte is driven, inputs are still holding it on return.
    task automatic send_frame(input logic [7:0] off, input logic [31:0] mask, input int len,
                              input logic [7:0] seed, input bit gaps, input bit good,
                              input bit en, input bit ok);
        logic [15:0] c = ref_crc(off, mask, len, seed);
        @(negedge clk);
        cfg_offset = off; cfg_mask = mask; cfg_enable = en;
        cfg_crc = ok ? c : c ^ 16'h0001;
        for (int i = 0; i < len; i++) begin
            if (gaps && (i % 3 == 2)) drive(1'b0, 1'b1, 1'b1, 1'b1, 8'hA5); // R7 idle noise
            drive(1'b1, i == 0, i == len - 1, good, fbyte(seed, i));
        end
    endtask

    // Checks the cycle after the eof byte, then the cycle after that.
    task automatic finish_frame(input bit expv, input string tag, input int base);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        check(wake_pulse == expv, tag, wake_pulse, expv);
        @(negedge clk);
        check(wake_pulse == 1'b0, {tag, " one-cycle R5"}, wake_pulse, 0);
        check(pulses - base == int'(expv), {tag, " pulse count"}, pulses - base, expv);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        check(wake_pulse == 1'b0, "R8 reset output", wake_pulse, 0);
        rst = 1'b0;
        @(negedge clk);
        check(wake_pulse == 1'b0, "R8 after reset", wake_pulse, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            base = pulses;
            send_frame(VECS[v].off, VECS[v].mask, int'(VECS[v].len), VECS[v].seed,
                       VECS[v].gaps, VECS[v].good, VECS[v].en, VECS[v].ok);
            finish_frame(VECS[v].exp, $sformatf("R1/R3/R4/R5/R6 vector %0d", v), base);
        end

        // R7: bytes outside a frame carry sof-less eof with an always-matching setup
        base = pulses;
        @(negedge clk);
        cfg_offset = 8'd12; cfg_mask = '0; cfg_crc = 16'hFFFF; cfg_enable = 1'b1;
        drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h11);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 8'h22);
        finish_frame(1'b0, "R7 stray bytes", base);

        // R7: restart inside a frame
        base = pulses;
        for (int i = 0; i < 10; i++) drive(1'b1, i == 0, 1'b0, 1'b1, 8'h5A);
        send_frame(8'd16, 32'h00000707, 30, 8'd21, 1'b0, 1'b1, 1'b1, 1'b1);
        finish_frame(1'b1, "R7 sof restart", base);

        // R8: reset mid-frame abandons the frame
        base = pulses;
        @(negedge clk);
        cfg_mask = '0; cfg_crc = 16'hFFFF;
        drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h01);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h02);
        @(negedge clk);
        rx_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 1'b0, 1'b1, 1'b1, 8'h03);
        finish_frame(1'b0, "R8 reset mid-frame", base);

        // R4: single-byte window, byte beyond mask changes nothing
        base = pulses;
        send_frame(8'd12, 32'h00000001, 50, 8'd33, 1'b0, 1'b1, 1'b1, 1'b1);
        finish_frame(1'b1, "R3 R4 single byte", base);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule